// File: doc/BRIEF.md
# Synthesizer Divider Configuration Loader

This block keeps the feedback divider value M (9 bits) and the output divider select N (1 bit) of a frequency synthesizer. It drives them from one of two load paths. The parallel path takes M from nine strap pins under an active-low strobe. While the strobe is low the pins pass straight through, and the value is held once the strobe goes high. A parallel load always leaves the output divider at ÷2.

The serial path uses a clock, a data pin and a load strobe. Bits are shifted in on rising serial clock edges while the parallel strobe is high. A rising load strobe moves the captured field to the outputs, and the field is held after the strobe falls. While the load strobe stays high, every serial clock edge updates the outputs directly. A serial transfer replaces a parallel-latched value.

All pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and edge detection is done in the clock domain. After reset the block captures the strapped M pins by itself, with N at ÷2.

Top module: `divcfg_loader`

## Requirements
- R1: While par_load_ni is low, m_o follows par_m_i. A pin change shows on m_o on the third rising clock edge after it.
- R2: Once par_load_ni is high, m_o keeps the value sampled before the rising edge of the strobe, even if par_m_i changes, until a serial transfer or a new low strobe.
- R3: Any parallel capture sets n_sel_o to 0 and out_div_o to 2.
- R4: With par_load_ni high, each rising edge of ser_clk_i shifts ser_data_i in as the new least significant bit. While ser_load_i is low, shifting leaves m_o and n_sel_o unchanged.
- R5: A rising edge of ser_load_i transfers the last 10 shifted bits to the outputs. The frame is 4 don't-care slots, then N, then M8 down to M0, so M0 is the last bit shifted. Bit 9 of the field is N and bits 8:0 are M.
- R6: After ser_load_i falls, the transferred values hold while further bits are shifted.
- R7: While ser_load_i is high, each rising ser_clk_i edge places the newly shifted 10-bit field on {n_sel_o, m_o}.
- R8: An N bit of 0 gives n_sel_o=0 and out_div_o=2 (÷2). An N bit of 1 gives n_sel_o=1 and out_div_o=4 (÷4).
- R9: A serial transfer overrides a parallel-latched M. A later low parallel strobe overrides a serial value.
- R10: In reset the outputs are M=0 and ÷2. Within 3 clock cycles after reset release, the strapped par_m_i value is captured with N at ÷2, even when par_load_ni is high.
- R11: ser_clk_i edges while par_load_ni is low shift nothing. The field captured earlier is still the one transferred by a later ser_load_i rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| par_load_ni | input | 1 | Active-low parallel load strobe |
| par_m_i | input | 9 | Parallel M strap pins |
| ser_clk_i | input | 1 | Serial shift clock |
| ser_data_i | input | 1 | Serial data |
| ser_load_i | input | 1 | Serial transfer strobe |
| m_o | output | 9 | Current feedback divider value |
| n_sel_o | output | 1 | Output divider select, 1 means ÷4 |
| out_div_o | output | 3 | Output divide ratio, 2 or 4 |

## Verification
The assertions assume the following about the pins:
- Each pin level lasts several system clocks.
- ser_data_i is settled before the ser_clk_i edge that samples it.
- par_m_i is stable around the rising edge of the parallel strobe.

Under these conditions, the synchronized level and the single-cycle edge pulse always describe the same pin event. The stimulus holds every pin phase for at least four clock cycles. It changes data only while the serial clock is low, and it moves strobes only between serial clock pulses.

// File: rtl/divcfg_pkg.sv
package divcfg_pkg;
  localparam int unsigned M_W     = 9;
  localparam int unsigned CFG_W   = M_W + 1;
  localparam int unsigned DIV_W   = 3;
  localparam int unsigned PIN_W   = M_W + 4;

  typedef struct packed {
    logic           n_sel;
    logic [M_W-1:0] m;
  } div_cfg_t;

  function automatic logic [DIV_W-1:0] ratio_of(input logic n_sel);
    return n_sel ? DIV_W'(4) : DIV_W'(2);
  endfunction
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else         pipe_q <= {pipe_q[STAGES-2:0], d_i};
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/edge_det.sv
module edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R4
endmodule

// File: rtl/ser_shift.sv
module ser_shift #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         shift_en_i,
  input  logic         din_i,
  output logic [W-1:0] field_q_o,
  output logic [W-1:0] field_d_o
);
  logic [W-1:0] sr_q;

  // leading frame slots fall off the top; only the field is stored
  assign field_d_o = {sr_q[W-2:0], din_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= field_d_o;
  end

  assign field_q_o = sr_q;

  AST_SHIFT_LSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> field_q_o[0] == $past(din_i)); // R4
  AST_SHIFT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(field_q_o)); // R11
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import divcfg_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             par_load_ni,
  input  logic [M_W-1:0]   par_m_i,
  input  logic             ser_clk_i,
  input  logic             ser_data_i,
  input  logic             ser_load_i,
  output logic [M_W-1:0]   m_o,
  output logic             n_sel_o,
  output logic [DIV_W-1:0] out_div_o
);
  localparam int unsigned BOOT_W = $clog2(SYNC_STAGES + 2);
  localparam logic [BOOT_W-1:0] BOOT_AT = BOOT_W'(SYNC_STAGES);

  logic [PIN_W-1:0] pins_s;
  logic [M_W-1:0]   par_m_s;
  logic             pl_n_s, sl_s, sck_s, sdat_s;
  logic             sl_rise, sck_rise, shift_en;
  logic [CFG_W-1:0] field_q, field_d;
  logic [BOOT_W-1:0] boot_cnt_q;
  logic             boot_fire, boot_done;
  div_cfg_t         cfg_q;

  bit_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({par_m_i, par_load_ni, ser_load_i, ser_clk_i, ser_data_i}),
    .q_o   (pins_s)
  );

  assign {par_m_s, pl_n_s, sl_s, sck_s, sdat_s} = pins_s;

  edge_det u_sl_edge  (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sl_s),  .rise_o(sl_rise));
  edge_det u_sck_edge (.clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(sck_s), .rise_o(sck_rise));

  assign shift_en = pl_n_s & sck_rise;

  ser_shift #(.W(CFG_W)) u_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_en_i(shift_en),
    .din_i     (sdat_s),
    .field_q_o (field_q),
    .field_d_o (field_d)
  );

  // wait for the synchronizer to fill, then capture straps once
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         boot_cnt_q <= '0;
    else if (!boot_done) boot_cnt_q <= boot_cnt_q + 1'b1;
  end

  assign boot_fire = (boot_cnt_q == BOOT_AT);
  assign boot_done = (boot_cnt_q > BOOT_AT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q <= '0;
    end else if (boot_fire || !pl_n_s) begin
      cfg_q.m     <= par_m_s;
      cfg_q.n_sel <= 1'b0;
    end else if (sck_rise && sl_s) begin
      cfg_q <= div_cfg_t'(field_d);
    end else if (sl_rise) begin
      cfg_q <= div_cfg_t'(field_q);
    end
  end

  assign m_o       = cfg_q.m;
  assign n_sel_o   = cfg_q.n_sel;
  assign out_div_o = ratio_of(cfg_q.n_sel);

  AST_PAR_TRANSPARENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pl_n_s |=> m_o == $past(par_m_s)); // R1
  AST_PAR_DIV2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pl_n_s |=> (!n_sel_o && out_div_o == DIV_W'(2))); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done && pl_n_s && !sck_rise && !sl_rise) |=> ($stable(m_o) && $stable(n_sel_o))); // R2
  AST_SER_TRANSFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done && pl_n_s && sl_rise && !sck_rise) |=> ({n_sel_o, m_o} == $past(field_q))); // R5
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boot_done && pl_n_s && sl_s && sck_rise) |=> ({n_sel_o, m_o} == field_q)); // R7
  AST_BOOT_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_fire |=> (m_o == $past(par_m_s) && !n_sel_o)); // R10
endmodule

// File: tb/divcfg_loader_tb.sv
module divcfg_loader_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       par_load_n = 1'b1;
  logic [8:0] par_m = '0;
  logic       ser_clk = 1'b0;
  logic       ser_data = 1'b0;
  logic       ser_load = 1'b0;
  logic [8:0] m_o;
  logic       n_sel_o;
  logic [2:0] out_div_o;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;
  logic [9:0] model_sr = '0;

  always #4 clk = ~clk;

  divcfg_loader dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .par_load_ni(par_load_n),
    .par_m_i    (par_m),
    .ser_clk_i  (ser_clk),
    .ser_data_i (ser_data),
    .ser_load_i (ser_load),
    .m_o        (m_o),
    .n_sel_o    (n_sel_o),
    .out_div_o  (out_div_o)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_cfg(input string tag, input logic [8:0] em, input logic en);
    chk({tag, " m"}, 32'(m_o), 32'(em));
    chk({tag, " n"}, 32'(n_sel_o), 32'(en));
    chk({tag, " div"}, 32'(out_div_o), en ? 32'd4 : 32'd2);
  endtask

  task automatic send_bit(input logic b, input bit shifts);
    ser_data = b;
    step(4);
    ser_clk = 1'b1;
    step(4);
    ser_clk = 1'b0;
    step(4);
    if (shifts) model_sr = {model_sr[8:0], b};
  endtask

  task automatic send_frame(input logic n, input logic [8:0] m);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b1);
    send_bit(n, 1'b1);
    for (int i = 8; i >= 0; i--) send_bit(m[i], 1'b1);
  endtask

  task automatic pulse_load();
    ser_load = 1'b1;
    step(5);
    ser_load = 1'b0;
    step(5);
  endtask

  task automatic t_reset();
    par_m = 9'h0A5;
    par_load_n = 1'b1;
    step(3);
    chk_cfg("R10 reset state", 9'h000, 1'b0);
    rst_n = 1'b1;
    step(6);
    chk_cfg("R10 strap capture", 9'h0A5, 1'b0);
  endtask

  task automatic t_par_transparent();
    logic [8:0] vals [3] = '{9'h1F3, 9'h07D, 9'h100};
    par_load_n = 1'b0;
    foreach (vals[i]) begin
      par_m = vals[i];
      step(5);
      chk_cfg("R1 R3 transparent", vals[i], 1'b0);
    end
  endtask

  task automatic t_par_latch();
    par_m = 9'h0C8;
    step(5);
    par_load_n = 1'b1;
    step(5);
    par_m = 9'h033;
    step(5);
    chk_cfg("R2 latched", 9'h0C8, 1'b0);
  endtask

  task automatic t_serial();
    send_frame(1'b1, 9'h15A);
    chk_cfg("R4 shift no effect", 9'h0C8, 1'b0);
    pulse_load();
    chk_cfg("R5 R8 R9 transfer div4", 9'h15A, 1'b1);
    send_frame(1'b0, 9'h0AA);
    chk_cfg("R6 hold after fall", 9'h15A, 1'b1);
    pulse_load();
    chk_cfg("R5 R8 transfer div2", 9'h0AA, 1'b0);
  endtask

  task automatic t_pass_through();
    logic [9:0] held;
    ser_load = 1'b1;
    step(5);
    chk("R7 rise transfer", 32'({n_sel_o, m_o}), 32'(model_sr));
    for (int i = 0; i < 12; i++) begin
      send_bit(((i * 7) % 3) == 1, 1'b1);
      chk("R7 pass through", 32'({n_sel_o, m_o}), 32'(model_sr));
    end
    ser_load = 1'b0;
    step(5);
    held = model_sr;
    for (int i = 0; i < 3; i++) send_bit(1'b1, 1'b1);
    chk("R6 frozen", 32'({n_sel_o, m_o}), 32'(held));
  endtask

  task automatic t_par_blocks_shift();
    send_frame(1'b1, 9'h1C3);
    par_m = 9'h055;
    par_load_n = 1'b0;
    step(5);
    chk_cfg("R9 R3 parallel over serial", 9'h055, 1'b0);
    for (int i = 0; i < 5; i++) send_bit(1'b0, 1'b0);
    chk_cfg("R11 outputs during blocked shift", 9'h055, 1'b0);
    par_load_n = 1'b1;
    step(5);
    pulse_load();
    chk_cfg("R11 field kept", 9'h1C3, 1'b1);
  endtask

  initial begin
    t_reset();
    t_par_transparent();
    t_par_latch();
    t_serial();
    t_pass_through();
    t_par_blocks_shift();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      vectors++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule